// File: doc/BRIEF.md
# Accumulator ALU with status flags

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle it takes a 3-bit operation code, the accumulator value, a second operand and a 4-bit immediate shift amount. When its enable input is high, it registers an 8-bit result and four status flags on the rising clock edge: negative, zero, carry and overflow. The surrounding controller raises the enable when the top bit of the instruction opcode is zero. It passes the three low opcode bits through unchanged as the operation code.

The accumulator is the first operand of every operation except negate. Negate uses only the second operand. The two shifts take their amount from the immediate field and ignore the second operand. The carry and overflow flags are defined so that a following conditional branch can test signed and unsigned orderings directly: after a subtract, carry means "no borrow".

Top module: `accu_alu`

## Requirements
- R1: Operation code 000 adds the two operands modulo 256. C is the carry out of bit 7.
- R2: Operation code 001 subtracts the second operand from the accumulator modulo 256. C is 1 exactly when the accumulator is greater than or equal to the second operand, both taken as unsigned.
- R3: Operation code 010 gives the two's complement negation of the second operand and ignores the accumulator. C is 1 exactly when the second operand is 0. V is 1 exactly when the second operand is 0x80.
- R4: For add and subtract, V is 1 exactly when the result overflows in two's-complement arithmetic.
- R5: Operation codes 011, 100 and 101 give bitwise AND, inclusive OR and exclusive OR of the two operands. Both C and V are cleared.
- R6: Operation code 110 shifts the accumulator left by the 4-bit amount (0 to 15) and fills with zeros. C is the last bit shifted out. An amount of 0 leaves the value unchanged with C=0. An amount of 8 or more gives 0. V is cleared.
- R7: Operation code 111 shifts the accumulator right logically by the 4-bit amount. C is the last bit shifted out. An amount of 0 leaves the value unchanged with C=0. An amount of 8 or more gives 0. V is cleared.
- R8: N equals bit 7 of the registered result. Z is 1 exactly when the registered result is zero.
- R9: Result and flags change only at a rising clock edge. They show the operation presented with the enable high in the cycle before that edge.
- R10: While the enable is low, result and flags keep their values whatever the other inputs do.
- R11: A synchronous active-high reset clears the result and all four flags at the next rising edge, even when the enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Perform the operation at this edge |
| op | input | 3 | Operation code |
| acc | input | 8 | Accumulator operand |
| opnd | input | 8 | Second operand |
| shamt | input | 4 | Immediate shift amount |
| result | output | 8 | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
Reset and an enabled operation can fall in the same cycle. The bench provokes this by holding the reset high while it presents an addition with a nonzero sum and the enable high. It then judges that the edge leaves result and flags cleared rather than holding the sum. A related overlap is a disabled cycle that directly follows an operation which set carry and overflow. New operands are presented in that cycle, and the bench confirms that both the flags and the result still read their earlier values one edge later.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_NEG = 3'b010,
    OP_AND = 3'b011,
    OP_IOR = 3'b100,
    OP_XOR = 3'b101,
    OP_SHL = 3'b110,
    OP_SHR = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int DATA_W = 8
) (
  input  alu_pkg::alu_op_e    op,
  input  logic [DATA_W-1:0]   acc,
  input  logic [DATA_W-1:0]   opnd,
  output logic [DATA_W-1:0]   sum,
  output logic                carry,
  output logic                ovf
);
  import alu_pkg::*;

  localparam int MSB = DATA_W - 1;

  logic              invert;
  logic [DATA_W-1:0] lhs;
  logic [DATA_W-1:0] rhs;
  logic [DATA_W:0]   total;

  // One adder serves add, subtract and negate: subtract and negate
  // feed the inverted second operand with a carry-in of one.
  always_comb begin
    invert = (op != OP_ADD);
    lhs    = (op == OP_NEG) ? '0 : acc;
    rhs    = invert ? ~opnd : opnd;
    total  = {1'b0, lhs} + {1'b0, rhs} + {{DATA_W{1'b0}}, invert};
    sum    = total[DATA_W-1:0];
    carry  = total[DATA_W];
    ovf    = (lhs[MSB] == rhs[MSB]) && (sum[MSB] != lhs[MSB]);
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int DATA_W = 8
) (
  input  alu_pkg::alu_op_e    op,
  input  logic [DATA_W-1:0]   acc,
  input  logic [DATA_W-1:0]   opnd,
  output logic [DATA_W-1:0]   res
);
  import alu_pkg::*;

  always_comb begin
    unique case (op)
      OP_AND:  res = acc & opnd;
      OP_IOR:  res = acc | opnd;
      OP_XOR:  res = acc ^ opnd;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int DATA_W  = 8,
  parameter int SHAMT_W = 4
) (
  input  logic                to_right,
  input  logic [DATA_W-1:0]   acc,
  input  logic [SHAMT_W-1:0]  amount,
  output logic [DATA_W-1:0]   res,
  output logic                out_bit
);

  localparam int WIDE_W = 2 * DATA_W;

  logic [WIDE_W-1:0] left_w;
  logic [WIDE_W-1:0] right_w;

  // The operand sits in a double-width word; the bit just past the
  // result window is the last one pushed out, zero for amount 0 or
  // for amounts beyond the operand width.
  always_comb begin
    left_w  = {{DATA_W{1'b0}}, acc} << amount;
    right_w = {acc, {DATA_W{1'b0}}} >> amount;
    if (to_right) begin
      res     = right_w[WIDE_W-1:DATA_W];
      out_bit = right_w[DATA_W-1];
    end else begin
      res     = left_w[DATA_W-1:0];
      out_bit = left_w[DATA_W];
    end
  end

endmodule

// File: rtl/accu_alu.sv
module accu_alu #(
  parameter int DATA_W  = 8,
  parameter int SHAMT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [2:0]         op,
  input  logic [DATA_W-1:0]  acc,
  input  logic [DATA_W-1:0]  opnd,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DATA_W-1:0]  result,
  output logic               flag_n,
  output logic               flag_z,
  output logic               flag_c,
  output logic               flag_v
);
  import alu_pkg::*;

  localparam int MSB = DATA_W - 1;

  alu_op_e           op_e;
  logic [DATA_W-1:0] arith_res;
  logic              arith_c;
  logic              arith_v;
  logic [DATA_W-1:0] logic_res;
  logic [DATA_W-1:0] shift_res;
  logic              shift_c;

  logic [DATA_W-1:0] next_res;
  alu_flags_t        next_flg;
  alu_flags_t        flg_q;
  logic [DATA_W-1:0] res_q;

  assign op_e = alu_op_e'(op);

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .op    (op_e),
    .acc   (acc),
    .opnd  (opnd),
    .sum   (arith_res),
    .carry (arith_c),
    .ovf   (arith_v)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op   (op_e),
    .acc  (acc),
    .opnd (opnd),
    .res  (logic_res)
  );

  alu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .to_right (op[0]),
    .acc      (acc),
    .amount   (shamt),
    .res      (shift_res),
    .out_bit  (shift_c)
  );

  always_comb begin
    unique case (op_e)
      OP_ADD, OP_SUB, OP_NEG: begin
        next_res   = arith_res;
        next_flg.c = arith_c;
        next_flg.v = arith_v;
      end
      OP_SHL, OP_SHR: begin
        next_res   = shift_res;
        next_flg.c = shift_c;
        next_flg.v = 1'b0;
      end
      default: begin
        next_res   = logic_res;
        next_flg.c = 1'b0;
        next_flg.v = 1'b0;
      end
    endcase
    next_flg.n = next_res[MSB];
    next_flg.z = (next_res == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      flg_q <= '0;
    end else if (en) begin
      res_q <= next_res;
      flg_q <= next_flg;
    end
  end

  assign result = res_q;
  assign flag_n = flg_q.n;
  assign flag_z = flg_q.z;
  assign flag_c = flg_q.c;
  assign flag_v = flg_q.v;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (result == '0) && !flag_n && !flag_z && !flag_c && !flag_v); // R11

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(result) && $stable(flag_n) && $stable(flag_z)
            && $stable(flag_c) && $stable(flag_v)); // R10

  AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (rst)
    en |=> flag_n == result[MSB]); // R8

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    en |=> flag_z == (result == '0)); // R8

  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'b000) |=>
      flag_c == (({1'b0, $past(acc)} + {1'b0, $past(opnd)}) >> DATA_W)); // R1

  AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'b001) |=> flag_c == ($past(acc) >= $past(opnd))); // R2

  AST_NEG_IGNORES_ACC: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'b010) |=> result == DATA_W'(-$past(opnd))); // R3

  AST_LOGIC_CLEARS_CV: assert property (@(posedge clk) disable iff (rst)
    (en && (op == 3'b011 || op == 3'b100 || op == 3'b101)) |=>
      !flag_c && !flag_v); // R5

  AST_SHL_ZERO_AMT: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'b110 && shamt == '0) |=>
      (result == $past(acc)) && !flag_c); // R6

  AST_SHR_WIDE_AMT: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'b111 && int'(shamt) >= DATA_W) |=>
      (result == '0) && flag_z && !flag_v); // R7

endmodule

// File: tb/accu_alu_bench.sv
`timescale 1ns/1ps
module accu_alu_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       en;
  logic [2:0] op;
  logic [7:0] acc;
  logic [7:0] opnd;
  logic [3:0] shamt;
  logic [7:0] result;
  logic       flag_n, flag_z, flag_c, flag_v;

  int tests  = 0;
  int failed = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  accu_alu u_accu_alu (
    .clk(clk), .rst(rst), .en(en), .op(op), .acc(acc), .opnd(opnd),
    .shamt(shamt), .result(result), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v)
  );

  // op, acc, opnd, shamt, expected result, expected {N,Z,C,V}
  localparam int NV = 24;
  localparam logic [34:0] VEC [NV] = '{
    {3'd0, 8'h10, 8'h20, 4'd0, 8'h30, 4'b0000},
    {3'd0, 8'hFF, 8'h01, 4'd0, 8'h00, 4'b0110},
    {3'd0, 8'h7F, 8'h01, 4'd0, 8'h80, 4'b1001},
    {3'd0, 8'h80, 8'h80, 4'd0, 8'h00, 4'b0111},
    {3'd1, 8'h05, 8'h03, 4'd0, 8'h02, 4'b0010},
    {3'd1, 8'h03, 8'h05, 4'd0, 8'hFE, 4'b1000},
    {3'd1, 8'h80, 8'h01, 4'd0, 8'h7F, 4'b0011},
    {3'd1, 8'h42, 8'h42, 4'd0, 8'h00, 4'b0110},
    {3'd2, 8'h55, 8'h01, 4'd0, 8'hFF, 4'b1000},
    {3'd2, 8'h00, 8'h01, 4'd0, 8'hFF, 4'b1000},
    {3'd2, 8'h33, 8'h00, 4'd0, 8'h00, 4'b0110},
    {3'd2, 8'h12, 8'h80, 4'd0, 8'h80, 4'b1001},
    {3'd3, 8'hF0, 8'h3C, 4'd0, 8'h30, 4'b0000},
    {3'd4, 8'h0F, 8'h80, 4'd0, 8'h8F, 4'b1000},
    {3'd5, 8'hAA, 8'hAA, 4'd0, 8'h00, 4'b0100},
    {3'd6, 8'h81, 8'h00, 4'd1, 8'h02, 4'b0010},
    {3'd6, 8'h81, 8'hFF, 4'd0, 8'h81, 4'b1000},
    {3'd6, 8'h01, 8'h00, 4'd8, 8'h00, 4'b0110},
    {3'd6, 8'hFF, 8'h00, 4'd9, 8'h00, 4'b0100},
    {3'd6, 8'h0F, 8'h00, 4'd4, 8'hF0, 4'b1000},
    {3'd7, 8'h81, 8'h00, 4'd1, 8'h40, 4'b0010},
    {3'd7, 8'h80, 8'h00, 4'd8, 8'h00, 4'b0110},
    {3'd7, 8'hFF, 8'h00, 4'd15, 8'h00, 4'b0100},
    {3'd7, 8'h90, 8'h00, 4'd4, 8'h09, 4'b0000}
  };

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0: return "R1/R4";
      3'd1: return "R2/R4";
      3'd2: return "R3";
      3'd3, 3'd4, 3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] actual, input logic [7:0] expected);
    tests++;
    if (actual !== expected) begin
      failed++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, actual, expected);
    end
  endtask

  function automatic logic [7:0] flags_now();
    return {4'b0, flag_n, flag_z, flag_c, flag_v};
  endfunction

  // Drive at a falling edge; the result is registered at the next
  // rising edge and sampled at the falling edge after it.
  task automatic apply(input logic e, input logic [2:0] o, input logic [7:0] a,
                       input logic [7:0] b, input logic [3:0] s);
    @(negedge clk);
    en = e; op = o; acc = a; opnd = b; shamt = s;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; op = '0; acc = '0; opnd = '0; shamt = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", "reset result", result, 8'h00);
    check("R11", "reset flags", flags_now(), 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      v = VEC[i];
      apply(1'b1, v[34:32], v[31:24], v[23:16], v[15:12]);
      check(tag_of(v[34:32]), "result", result, v[11:4]);
      // R8 covers N and Z inside the flag nibble
      check({tag_of(v[34:32]), "/R8"}, "flags NZCV", flags_now(), {4'b0, v[3:0]});
    end

    // R10: enable low after an op that set C and V
    apply(1'b1, 3'd0, 8'h80, 8'h80, 4'd0);
    apply(1'b0, 3'd3, 8'h12, 8'h34, 4'd0);
    check("R10", "held result", result, 8'h00);
    check("R10", "held flags", flags_now(), 8'h07);
    apply(1'b0, 3'd6, 8'hFF, 8'h00, 4'd1);
    check("R10", "held result 2", result, 8'h00);

    // R9: no change before the edge, change right after it
    @(negedge clk);
    en = 1'b1; op = 3'd0; acc = 8'h21; opnd = 8'h01; shamt = 4'd0;
    #1;
    check("R9", "before edge", result, 8'h00);
    @(posedge clk); #1;
    check("R9", "after edge", result, 8'h22);
    check("R9", "flags after edge", flags_now(), 8'h00);

    // R11: reset wins over an enabled add in the same cycle
    @(negedge clk);
    rst = 1'b1; en = 1'b1; op = 3'd0; acc = 8'hFF; opnd = 8'h82;
    @(negedge clk);
    check("R11", "reset beats enable result", result, 8'h00);
    check("R11", "reset beats enable flags", flags_now(), 8'h00);
    rst = 1'b0; en = 1'b0;
    @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

endmodule